// File: doc/BRIEF.md
# Block-Lock Write Guard

This unit sits beside the nonvolatile array controller of a small serial-access memory. It holds a one-byte configuration register and tells the controller, for every pending nonvolatile write, whether that write may go ahead. A two-bit range code in the register selects how much of the top of the array is read-only. An enable bit in the same register arms an external hardware guard input. While the guard is armed and driven low, the register itself is frozen, including the enable bit.

The array size is 16, 64 or 128 Kbit, set by `ARRAY_KBIT`. The configuration register is reached at the all-ones address. A register update is staged as exactly one byte between a sequence-start strobe and a commit strobe. An accepted commit starts a programming interval of `PROG_CYCLES` clocks, and the new value becomes visible when that interval ends. The unit also drives a request to clear the controller's write-enable latch whenever the hardware guard is holding, a sequence is broken, or a programming interval finishes.

Top module: `bl_guard_unit`

## Requirements
- R1: Reset loads the register from `CTRL_RESET` (default 00h), so `rd_data` reads 00h and an in-array address is permitted.
- R2: `rd_data` places the guard-enable bit at bit 7 and the range code at bits 3:2. All other bits always read 0, so writing FFh reads back 8Ch.
- R3: For array addresses, code 00 protects nothing, 01 protects the top quarter (0600h–07FFh at 16 Kbit), 10 the top half (0400h–07FFh), and 11 the whole array. A protected address drives `permit` low.
- R4: An in-array address outside the protected range is always permitted, whatever `guard_n` and bit 7 are. Addresses at or above the array size, other than FFFFh, are never permitted.
- R5: Address FFFFh is not covered by the range code. It is permitted unless the hardware lock is active, and the lock is active when `guard_n` is 0 and bit 7 is 1.
- R6: While bit 7 is 0, `guard_n` has no effect: register updates succeed and `wel_clear` is not raised by it.
- R7: While the hardware lock is active, commits are refused, the register (bit 7 included) keeps its value, and `wel_clear` stays high.
- R8: A second byte loaded in one sequence is a violation. It pulses `wel_clear` in that cycle, and the following commit changes nothing.
- R9: A commit with no staged byte is refused. It pulses `wel_clear` and leaves the register unchanged.
- R10: If the hardware lock becomes active after a byte is staged and before the commit, the staged update is cancelled. Once a commit has been accepted, the lock becoming active does not stop it.
- R11: An accepted commit on clock edge k makes the new value visible after edge k+`PROG_CYCLES`. `wel_clear` is high in the last cycle of the interval, and loads and commits issued during the interval are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_n | input | 1 | Hardware guard input, low means hold |
| chk_addr | input | 16 | Target address of the pending nonvolatile write |
| cfg_begin | input | 1 | Starts a register update sequence and clears staging |
| cfg_load | input | 1 | Strobes one byte from cfg_data into staging |
| cfg_data | input | 8 | Byte to stage |
| cfg_commit | input | 1 | Requests programming of the staged byte |
| permit | output | 1 | High when a write to chk_addr is allowed |
| rd_data | output | 8 | Register readback |
| wel_clear | output | 1 | Request to clear the write-enable latch |

## Verification
The checker watches the readback on every cycle. It confirms that the unused bits stay zero, that the register changes only at the end of a programming interval, and that the register holds while the lock is active. It also checks that the all-ones address follows the lock, that the full-lock and no-lock codes decide the permit, and that out-of-array addresses are refused. The bench scenarios are needed for the behaviour that depends on sequence history and exact timing. These are the cancellation of a staged byte when the guard falls, the survival of an already accepted commit, the exact edge on which a new value appears, and the quarter and half boundaries of the range code.

// File: rtl/bl_guard_pkg.sv
`timescale 1ns/1ps
package bl_guard_pkg;
  localparam logic [15:0] CTRL_ADDR = 16'hFFFF;
  localparam int          EN_POS    = 7;
  localparam int          CODE_LO   = 2;
  localparam logic [7:0]  LIVE_MASK = 8'h8C;

  typedef struct packed {
    logic       en;
    logic [1:0] code;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
    ctrl_t c;
    c.en   = b[EN_POS];
    c.code = b[CODE_LO +: 2];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    logic [7:0] b;
    b = '0;
    b[EN_POS]       = c.en;
    b[CODE_LO +: 2] = c.code;
    return b;
  endfunction

  // Lowest protected array address for a range code; size means none.
  function automatic logic [16:0] lock_floor(input logic [1:0] code, input int size);
    int f;
    case (code)
      2'b00:   f = size;
      2'b01:   f = size - (size >> 2);
      2'b10:   f = size >> 1;
      default: f = 0;
    endcase
    return 17'(f);
  endfunction
endpackage

// File: rtl/bl_range_check.sv
`timescale 1ns/1ps
module bl_range_check
  import bl_guard_pkg::*;
#(
  parameter int ARRAY_KBIT = 16
) (
  input  logic [15:0] addr,
  input  ctrl_t       ctrl,
  input  logic        hw_lock,
  output logic        permit
);
  localparam int SIZE = ARRAY_KBIT * 128;
  localparam int AW   = $clog2(SIZE);

  logic [16:0] floor_tab [4];
  logic [16:0] floor_sel;
  logic        in_array;
  logic        is_ctrl;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_floor
      assign floor_tab[g] = lock_floor(2'(g), SIZE);
    end
  endgenerate

  assign floor_sel = floor_tab[ctrl.code];
  assign in_array  = (addr[15:AW] == '0);
  assign is_ctrl   = (addr == CTRL_ADDR);

  always_comb begin
    if (is_ctrl) permit = !hw_lock;
    else         permit = in_array && ({1'b0, addr} < floor_sel);
  end
endmodule

// File: rtl/bl_prog_timer.sv
`timescale 1ns/1ps
module bl_prog_timer #(
  parameter int PROG_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            rem_q <= '0;
    else if (start)        rem_q <= CW'(PROG_CYCLES);
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign busy = (rem_q != '0);
  assign done = (rem_q == CW'(1));
endmodule

// File: rtl/bl_cfg_stage.sv
`timescale 1ns/1ps
module bl_cfg_stage
  import bl_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_begin,
  input  logic       byte_load,
  input  logic [7:0] byte_in,
  input  logic       commit,
  input  logic       busy,
  input  logic       hw_lock,
  output ctrl_t      staged,
  output logic       commit_ok,
  output logic       commit_bad,
  output logic       viol
);
  logic  have_q;
  logic  abort_q;
  ctrl_t byte_q;
  logic  active;

  assign active     = !seq_begin && !busy;
  assign viol       = active && byte_load && have_q;
  assign commit_ok  = active && commit && have_q && !abort_q && !hw_lock;
  assign commit_bad = active && commit && !commit_ok;
  assign staged     = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      abort_q <= 1'b0;
      byte_q  <= '0;
    end else if (seq_begin || (active && commit)) begin
      have_q  <= 1'b0;
      abort_q <= 1'b0;
    end else if (active) begin
      if (byte_load) begin
        if (!have_q) begin
          have_q <= 1'b1;
          byte_q <= ctrl_from_byte(byte_in);
        end else begin
          abort_q <= 1'b1;
        end
      end
      if (hw_lock && have_q) abort_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bl_guard_unit.sv
`timescale 1ns/1ps
module bl_guard_unit
  import bl_guard_pkg::*;
#(
  parameter int         ARRAY_KBIT  = 16,
  parameter logic [7:0] CTRL_RESET  = 8'h00,
  parameter int         PROG_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        guard_n,
  input  logic [15:0] chk_addr,
  input  logic        cfg_begin,
  input  logic        cfg_load,
  input  logic [7:0]  cfg_data,
  input  logic        cfg_commit,
  output logic        permit,
  output logic [7:0]  rd_data,
  output logic        wel_clear
);
  ctrl_t ctrl_q;
  ctrl_t pend_q;
  ctrl_t staged;
  logic  hw_lock;
  logic  commit_ok;
  logic  commit_bad;
  logic  viol_evt;
  logic  prog_busy;
  logic  prog_done;

  assign hw_lock = !guard_n && ctrl_q.en;

  bl_cfg_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_begin  (cfg_begin),
    .byte_load  (cfg_load),
    .byte_in    (cfg_data),
    .commit     (cfg_commit),
    .busy       (prog_busy),
    .hw_lock    (hw_lock),
    .staged     (staged),
    .commit_ok  (commit_ok),
    .commit_bad (commit_bad),
    .viol       (viol_evt)
  );

  bl_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_ok),
    .busy  (prog_busy),
    .done  (prog_done)
  );

  bl_range_check #(.ARRAY_KBIT(ARRAY_KBIT)) u_range (
    .addr    (chk_addr),
    .ctrl    (ctrl_q),
    .hw_lock (hw_lock),
    .permit  (permit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_from_byte(CTRL_RESET);
      pend_q <= ctrl_from_byte(CTRL_RESET);
    end else begin
      if (commit_ok) pend_q <= staged;
      if (prog_done) ctrl_q <= pend_q;
    end
  end

  assign rd_data   = ctrl_to_byte(ctrl_q);
  assign wel_clear = hw_lock || viol_evt || commit_bad || prog_done;
endmodule

// File: rtl/bl_guard_unit_chk.sv
`timescale 1ns/1ps
module bl_guard_unit_chk #(
  parameter int ARRAY_KBIT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        guard_n,
  input logic [15:0] chk_addr,
  input logic        permit,
  input logic [7:0]  rd_data,
  input logic        wel_clear,
  input logic        prog_busy,
  input logic        prog_done,
  input logic        viol_evt
);
  localparam int SIZE = ARRAY_KBIT * 128;

  logic locked;
  logic in_arr;
  assign locked = !guard_n && rd_data[7];
  assign in_arr = ({16'd0, chk_addr} < SIZE);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 8'h73) == 8'h00); // R2
  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:2] == 2'b11 && in_arr) |-> !permit); // R3
  AST_FREE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:2] == 2'b00 && in_arr) |-> permit); // R4
  AST_OUTSIDE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_arr && chk_addr != 16'hFFFF) |-> !permit); // R4
  AST_CTRL_ADDR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_addr == 16'hFFFF) |-> (permit == !locked)); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !prog_busy) |=> $stable(rd_data)); // R7
  AST_LOCK_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> wel_clear); // R7
  AST_VIOL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> $stable(rd_data)); // R8
  AST_UPDATE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(rd_data)); // R11
endmodule

bind bl_guard_unit bl_guard_unit_chk #(.ARRAY_KBIT(ARRAY_KBIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .guard_n   (guard_n),
  .chk_addr  (chk_addr),
  .permit    (permit),
  .rd_data   (rd_data),
  .wel_clear (wel_clear),
  .prog_busy (prog_busy),
  .prog_done (prog_done),
  .viol_evt  (viol_evt)
);

// File: tb/bl_guard_unit_test.sv
`timescale 1ns/1ps
module bl_guard_unit_test;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        guard_n = 1'b1;
  logic [15:0] chk_addr = 16'h0000;
  logic        cfg_begin = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_data = 8'h00;
  logic        cfg_commit = 1'b0;
  logic        permit;
  logic [7:0]  rd_data;
  logic        wel_clear;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bl_guard_unit #(.ARRAY_KBIT(16), .CTRL_RESET(8'h00), .PROG_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .guard_n(guard_n), .chk_addr(chk_addr),
    .cfg_begin(cfg_begin), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .cfg_commit(cfg_commit), .permit(permit), .rd_data(rd_data),
    .wel_clear(wel_clear)
  );

  // {code[1:0], guard_n, addr[15:0], expected permit}; 16 Kbit array
  localparam logic [19:0] VEC [14] = '{
    {2'd0, 1'b1, 16'h0000, 1'b1},
    {2'd0, 1'b0, 16'h07FF, 1'b1},
    {2'd0, 1'b1, 16'h0800, 1'b0},
    {2'd0, 1'b1, 16'h1234, 1'b0},
    {2'd1, 1'b1, 16'h05FF, 1'b1},
    {2'd1, 1'b1, 16'h0600, 1'b0},
    {2'd1, 1'b0, 16'h05FF, 1'b1},
    {2'd2, 1'b1, 16'h03FF, 1'b1},
    {2'd2, 1'b1, 16'h0400, 1'b0},
    {2'd2, 1'b1, 16'h07FF, 1'b0},
    {2'd3, 1'b1, 16'h0000, 1'b0},
    {2'd3, 1'b1, 16'h07FF, 1'b0},
    {2'd3, 1'b1, 16'hFFFF, 1'b1},
    {2'd3, 1'b0, 16'hFFFF, 1'b1}
  };

  task automatic expect_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] b);
    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_load = 1'b1; cfg_data = b; tick(); cfg_load = 1'b0;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    repeat (P) tick();
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    #1;
    expect_eq("R1 reset readback", 16'(rd_data), 16'h00);
    expect_eq("R1 reset permit", 16'(permit), 16'h1);
    expect_eq("R1 reset wel_clear", 16'(wel_clear), 16'h0);

    cur = 2'd0;
    for (int i = 0; i < 14; i++) begin
      logic [19:0] v;
      v = VEC[i];
      @(negedge clk);
      if (v[19:18] != cur) begin
        guard_n = 1'b1;
        write_ctrl({4'b0000, v[19:18], 2'b00});
        cur = v[19:18];
      end
      guard_n  = v[17];
      chk_addr = v[16:1];
      #1;
      expect_eq("R3/R4/R5 vector permit", 16'(permit), 16'(v[0]));
    end

    @(negedge clk);
    guard_n = 1'b1; chk_addr = 16'h0000;
    write_ctrl(8'hFF);
    expect_eq("R2 masked readback", 16'(rd_data), 16'h8C);

    guard_n = 1'b0; chk_addr = 16'hFFFF; #1;
    expect_eq("R5 ctrl addr locked", 16'(permit), 16'h0);
    expect_eq("R7 wel_clear under lock", 16'(wel_clear), 16'h1);
    write_ctrl(8'h00);
    expect_eq("R7 locked write refused", 16'(rd_data), 16'h8C);
    guard_n = 1'b1; #1;
    expect_eq("R5 ctrl addr unlocked", 16'(permit), 16'h1);

    @(negedge clk);
    write_ctrl(8'h84);
    guard_n = 1'b0; chk_addr = 16'h0100; #1;
    expect_eq("R4 unprotected under lock", 16'(permit), 16'h1);
    chk_addr = 16'h0600; #1;
    expect_eq("R3 quarter still protected", 16'(permit), 16'h0);

    @(negedge clk);
    guard_n = 1'b1;
    write_ctrl(8'h80);
    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_load = 1'b1; cfg_data = 8'h88; tick(); cfg_load = 1'b0;
    guard_n = 1'b0; tick(); guard_n = 1'b1;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    repeat (P) tick();
    expect_eq("R10 staged byte cancelled", 16'(rd_data), 16'h80);

    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_load = 1'b1; cfg_data = 8'h84; tick(); cfg_load = 1'b0;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    guard_n = 1'b0;
    repeat (P) tick();
    expect_eq("R10 accepted commit completes", 16'(rd_data), 16'h84);
    guard_n = 1'b1;

    write_ctrl(8'h08);
    expect_eq("R6 enable cleared", 16'(rd_data), 16'h08);
    guard_n = 1'b0; #1;
    expect_eq("R6 no wel_clear when disabled", 16'(wel_clear), 16'h0);
    @(negedge clk);
    write_ctrl(8'h0C);
    expect_eq("R6 guard ignored", 16'(rd_data), 16'h0C);
    guard_n = 1'b1;

    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_load = 1'b1; cfg_data = 8'h00; tick();
    cfg_data = 8'h04; #1;
    expect_eq("R8 violation pulse", 16'(wel_clear), 16'h1);
    tick(); cfg_load = 1'b0;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    repeat (P) tick();
    expect_eq("R8 aborted sequence", 16'(rd_data), 16'h0C);

    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_commit = 1'b1; #1;
    expect_eq("R9 empty commit pulse", 16'(wel_clear), 16'h1);
    tick(); cfg_commit = 1'b0;
    repeat (P) tick();
    expect_eq("R9 empty commit no change", 16'(rd_data), 16'h0C);

    cfg_begin = 1'b1; tick(); cfg_begin = 1'b0;
    cfg_load = 1'b1; cfg_data = 8'h00; tick(); cfg_load = 1'b0;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    cfg_load = 1'b1; cfg_data = 8'hFF; tick(); cfg_load = 1'b0;
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    tick();
    expect_eq("R11 old value before end", 16'(rd_data), 16'h0C);
    expect_eq("R11 wel_clear at end", 16'(wel_clear), 16'h1);
    tick();
    expect_eq("R11 new value after interval", 16'(rd_data), 16'h00);
    expect_eq("R11 wel_clear released", 16'(wel_clear), 16'h0);
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    repeat (P) tick();
    expect_eq("R11 busy-time load ignored", 16'(rd_data), 16'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule